// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare Channels

This block is an 8-bit up-counter for a microcontroller-style peripheral set. A three-bit source field decides what advances the counter. The counter can be stopped, advanced by one of five prescaled tick strobes that arrive from outside the block, or advanced by a synchronized falling or rising edge of an external pin. A mode bit picks the counting sequence. In free-running mode the counter wraps past its maximum. In clear-on-match mode it returns to zero after it reaches the value in compare register A.

Two compare registers are checked against the counter all the time. The block keeps three event flags: overflow, match A and match B. Each flag drives an interrupt request through its own enable bit. A flag is cleared either by a per-flag acknowledge strobe or by a software write of one to that flag. Software reaches every register through a plain address/strobe port with a combinational read path.

Top module: `tick_timer8`

Register addresses: 0 control (bits 2:0 source, bit 3 clear-on-match), 1 counter, 2 compare A, 3 compare B, 4 interrupt enables, 5 flags. Flag and enable bit positions: bit 0 overflow, bit 1 match A, bit 2 match B. Source codes: 0 stop, 1..5 select `pre_tick[0]`..`pre_tick[4]`, 6 falling pin edge, 7 rising pin edge.

## Requirements
- R1: After reset every register (control, counter, compares, enables, flags) reads 0 and `irq` is 0.
- R2: With source code 0 the counter holds its value and no flag is set, whatever the tick strobes do.
- R3: Source codes 1..5 advance the counter by one on each cycle where `pre_tick[code-1]` is high, and the other strobes have no effect.
- R4: Source code 7 counts each rising edge of `ext_pin` and code 6 counts each falling edge. A pin change driven before clock edge k shows up in the counter after edge k+2, and the opposite edge is not counted.
- R5: A write to the counter register loads the written value even when a count or clear falls in the same cycle. That tick has no other effect.
- R6: In free-running mode (control bit 3 = 0), a tick at 255 wraps the counter to 0 and sets the overflow flag (bit 0). No other tick sets it.
- R7: In clear-on-match mode (control bit 3 = 1), a tick while the counter equals compare A loads 0 and sets the overflow flag. A wrap from 255 in this mode does not set it.
- R8: A match flag (bit 1 for A, bit 2 for B) is set by the tick that leaves the equal value, not on the cycle where equality first appears.
- R9: `irq` equals the bitwise AND of the flag register and the enable register.
- R10: Writing the flag register clears each flag whose written bit is 1 and leaves flags written with 0 unchanged.
- R11: `irq_ack[i]` clears flag i. A set event in the same cycle wins over the clear.
- R12: With `bus_rd` high, `bus_rdata` shows the addressed register. With `bus_rd` low it is 0. Compare and enable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| pre_tick | input | 5 | Prescaled tick strobes, divide 1/8/64/256/1024 |
| ext_pin | input | 1 | Asynchronous external count pin |
| irq_ack | input | 3 | Per-flag interrupt acknowledge |
| irq | output | 3 | Per-flag interrupt requests |

## Verification
A wrong counter state is visible on the next register read of address 1. The bench therefore reads the counter after every tick in its mode sweeps and compares it with an arithmetic model. A flag that is set a tick early or a tick late shows up on the flag read in that same cycle, so match timing is checked at single-tick granularity. A wrong synchronizer depth shifts the visible count by a whole cycle. To catch that, the pin-edge checks sample one cycle before and one cycle at the expected update.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int CNT_W  = 8;
    localparam int SEL_W  = 3;
    localparam int NDIV   = 5;
    localparam int NFLAG  = 3;
    localparam int ADDR_W = 3;

    localparam int FLG_OVF = 0;
    localparam int FLG_A   = 1;
    localparam int FLG_B   = 2;
    localparam int CTRL_MODE_BIT = SEL_W;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    localparam logic [SEL_W-1:0] SEL_STOP     = 3'd0;
    localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd6;
    localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd7;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] REG_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_IEN   = 3'd4;
    localparam logic [ADDR_W-1:0] REG_FLAG  = 3'd5;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_s;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [NFLAG-1:0] flags;
    } core_s;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             clr_mode;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [NFLAG-1:0] ien;
    } regs_s;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_o,
    output logic fall_o
);
    sync_s sy_q, sy_d;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
        rise_o  = sy_q.s2 && !sy_q.s3;
        fall_o  = !sy_q.s2 && sy_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);                                   // R4
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);                                   // R4
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr8_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [NDIV-1:0]  pre_tick,
    input  logic             ext_rise,
    input  logic             ext_fall,
    output logic             tick_o
);
    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < NDIV; i++) begin
            if (sel == SEL_W'(i + 1)) tick_o = pre_tick[i];
        end
        if (sel == SEL_EXT_FALL) tick_o = ext_fall;
        if (sel == SEL_EXT_RISE) tick_o = ext_rise;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [NFLAG-1:0] flag_w1c,
    input  logic [NFLAG-1:0] flag_ack,
    output logic [CNT_W-1:0] count_o,
    output logic [NFLAG-1:0] flags_o
);
    core_s            st_q, st_d;
    logic             step, hit_a, hit_b;
    logic [NFLAG-1:0] ev;

    always_comb begin
        st_d  = st_q;
        hit_a = (st_q.count == cmp_a);
        hit_b = (st_q.count == cmp_b);
        step  = tick && !cnt_wr;
        ev    = '0;
        if (cnt_wr) begin
            st_d.count = cnt_wdata;
        end else if (tick) begin
            if (clr_mode && hit_a) begin
                st_d.count   = '0;
                ev[FLG_OVF]  = 1'b1;
            end else begin
                st_d.count   = st_q.count + 1'b1;
                ev[FLG_OVF]  = !clr_mode && (st_q.count == CNT_MAX);
            end
        end
        ev[FLG_A]  = step && hit_a;
        ev[FLG_B]  = step && hit_b;
        st_d.flags = (st_q.flags & ~(flag_w1c | flag_ack)) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign flags_o = st_q.flags;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_o == $past(cnt_wdata)));             // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count_o));              // R2
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !clr_mode && count_o == CNT_MAX)
        |=> (count_o == '0 && flags_o[FLG_OVF]));              // R6
    AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && clr_mode && count_o == cmp_a)
        |=> (count_o == '0 && flags_o[FLG_OVF] && flags_o[FLG_A])); // R7
    AST_ACK_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ack[FLG_B] && !(tick && !cnt_wr && count_o == cmp_b))
        |=> !flags_o[FLG_B]);                                  // R11
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NDIV-1:0]   pre_tick,
    input  logic              ext_pin,
    input  logic [NFLAG-1:0]  irq_ack,
    output logic [NFLAG-1:0]  irq
);
    regs_s            rg_q, rg_d;
    logic             ext_rise, ext_fall, tick;
    logic             cnt_wr;
    logic [NFLAG-1:0] flag_w1c, flags;
    logic [CNT_W-1:0] count;

    tmr_pin_edge u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .rise_o(ext_rise), .fall_o(ext_fall)
    );

    tmr_tick_sel u_sel (
        .sel(rg_q.sel), .pre_tick(pre_tick),
        .ext_rise(ext_rise), .ext_fall(ext_fall), .tick_o(tick)
    );

    tmr_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_mode(rg_q.clr_mode),
        .cmp_a(rg_q.cmp_a), .cmp_b(rg_q.cmp_b),
        .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata),
        .flag_w1c(flag_w1c), .flag_ack(irq_ack),
        .count_o(count), .flags_o(flags)
    );

    always_comb begin
        rg_d     = rg_q;
        cnt_wr   = bus_wr && (bus_addr == REG_COUNT);
        flag_w1c = (bus_wr && bus_addr == REG_FLAG) ? bus_wdata[NFLAG-1:0] : '0;
        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL: begin
                    rg_d.sel      = bus_wdata[SEL_W-1:0];
                    rg_d.clr_mode = bus_wdata[CTRL_MODE_BIT];
                end
                REG_CMPA: rg_d.cmp_a = bus_wdata;
                REG_CMPB: rg_d.cmp_b = bus_wdata;
                REG_IEN:  rg_d.ien   = bus_wdata[NFLAG-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                REG_CTRL: begin
                    bus_rdata[SEL_W-1:0]     = rg_q.sel;
                    bus_rdata[CTRL_MODE_BIT] = rg_q.clr_mode;
                end
                REG_COUNT: bus_rdata = count;
                REG_CMPA:  bus_rdata = rg_q.cmp_a;
                REG_CMPB:  bus_rdata = rg_q.cmp_b;
                REG_IEN:   bus_rdata[NFLAG-1:0] = rg_q.ien;
                REG_FLAG:  bus_rdata[NFLAG-1:0] = flags;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = flags & rg_q.ien;

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.sel == SEL_STOP) |-> !tick);                     // R2
    AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ien == '0) |-> (irq == '0));                     // R9
    AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[FLG_OVF] && !tick) |=> !flags[FLG_OVF]);      // R11
endmodule

// File: tb/sim_tick_timer8.sv
module sim_tick_timer8;
    import tmr8_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [4:0] pre_tick = '0;
    logic       ext_pin = 1'b0;
    logic [2:0] irq_ack = '0;
    logic [2:0] irq;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer8 u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pre_tick(pre_tick), .ext_pin(ext_pin), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int exp_c, exp_f;
        int ca_list [3] = '{0, 3, 7};

        step(3);
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg%0d", a), v, 0);
        end
        chk("R1 irq", irq, 0);

        // R12: read back and read strobe gating
        wr(REG_CMPA, 8'hA5); wr(REG_CMPB, 8'h3C); wr(REG_IEN, 8'h05);
        rd(REG_CMPA, v); chk("R12 cmpa", v, 8'hA5);
        rd(REG_CMPB, v); chk("R12 cmpb", v, 8'h3C);
        rd(REG_IEN, v);  chk("R12 ien", v, 5);
        bus_addr = REG_CMPA; bus_rd = 1'b0; #1;
        chk("R12 rd low", bus_rdata, 0);
        wr(REG_IEN, 8'h00);

        // R2: stopped counter ignores strobes
        wr(REG_COUNT, 8'd7);
        wr(REG_FLAG, 8'h07);
        for (int k = 0; k < 20; k++) begin
            pre_tick = 5'h1F;
            step();
        end
        pre_tick = '0;
        rd(REG_COUNT, v); chk("R2 hold", v, 7);
        rd(REG_FLAG, v);  chk("R2 no flags", v, 0);

        // R3: each prescaled strobe selected alone
        for (int s = 1; s <= 5; s++) begin
            wr(REG_CTRL, 8'd0);
            wr(REG_COUNT, 8'd0);
            wr(REG_CTRL, 8'(s));
            exp_c = 0;
            for (int k = 0; k < 40; k++) begin
                pre_tick = 5'(k);
                if (k[s-1]) exp_c++;
                step();
            end
            pre_tick = '0;
            rd(REG_COUNT, v); chk($sformatf("R3 sel%0d", s), v, exp_c);
        end
        wr(REG_CTRL, 8'd0);

        // R4: rising then falling pin edges with latency
        wr(REG_COUNT, 8'd0);
        wr(REG_CTRL, 8'd7);
        exp_c = 0;
        for (int e = 0; e < 3; e++) begin
            ext_pin = 1'b1;
            step(2);
            rd(REG_COUNT, v); chk("R4 rise early", v, exp_c);
            step();
            exp_c++;
            rd(REG_COUNT, v); chk("R4 rise count", v, exp_c);
            ext_pin = 1'b0;
            step(4);
            rd(REG_COUNT, v); chk("R4 fall ignored", v, exp_c);
        end
        wr(REG_CTRL, 8'd6);
        for (int e = 0; e < 3; e++) begin
            ext_pin = 1'b1;
            step(4);
            rd(REG_COUNT, v); chk("R4 rise ignored", v, exp_c);
            ext_pin = 1'b0;
            step(2);
            rd(REG_COUNT, v); chk("R4 fall early", v, exp_c);
            step();
            exp_c++;
            rd(REG_COUNT, v); chk("R4 fall count", v, exp_c);
        end
        wr(REG_CTRL, 8'd0);

        // R5: write beats a concurrent tick
        wr(REG_COUNT, 8'h10);
        pre_tick = 5'b00001;
        wr(REG_CTRL, 8'd1);
        step(2);
        rd(REG_COUNT, v); chk("R5 ticking", v, 8'h12);
        wr(REG_COUNT, 8'h40);
        rd(REG_COUNT, v); chk("R5 write wins", v, 8'h40);
        step();
        rd(REG_COUNT, v); chk("R5 resume", v, 8'h41);
        pre_tick = '0;
        wr(REG_CTRL, 8'd0);

        // R6 R7 R8: sweep both modes against an arithmetic model
        for (int m = 0; m < 2; m++) begin
            for (int ci = 0; ci < 3; ci++) begin
                wr(REG_CTRL, 8'd0);
                wr(REG_COUNT, 8'd250);
                wr(REG_CMPA, 8'(ca_list[ci]));
                wr(REG_CMPB, 8'd5);
                wr(REG_FLAG, 8'h07);
                pre_tick = 5'b00001;
                wr(REG_CTRL, 8'((m << 3) | 1));
                exp_c = 250; exp_f = 0;
                for (int k = 0; k < 20; k++) begin
                    step();
                    if (exp_c == 5) exp_f |= 4;
                    if (exp_c == ca_list[ci]) exp_f |= 2;
                    if (m == 1 && exp_c == ca_list[ci]) begin
                        exp_c = 0; exp_f |= 1;
                    end else begin
                        if (m == 0 && exp_c == 255) exp_f |= 1;
                        exp_c = (exp_c + 1) % 256;
                    end
                    rd(REG_COUNT, v);
                    chk(m ? "R7 count" : "R6 count", v, exp_c);
                    rd(REG_FLAG, v);
                    chk(m ? "R7 R8 flags" : "R6 R8 flags", v, exp_f);
                end
                pre_tick = '0;
            end
        end
        wr(REG_CTRL, 8'd0);

        // R8: match flag appears one tick after equality
        wr(REG_CMPA, 8'h90); wr(REG_CMPB, 8'h21);
        wr(REG_COUNT, 8'h20); wr(REG_FLAG, 8'h07);
        wr(REG_CTRL, 8'd1);
        pre_tick = 5'b00001; step(); pre_tick = '0;
        rd(REG_COUNT, v); chk("R8 at equal", v, 8'h21);
        step(3);
        rd(REG_FLAG, v); chk("R8 not yet", v, 0);
        pre_tick = 5'b00001; step(); pre_tick = '0;
        rd(REG_FLAG, v); chk("R8 set next tick", v, 4);

        // R9: request gating
        chk("R9 disabled", irq, 0);
        wr(REG_IEN, 8'h04); chk("R9 enabled B", irq, 4);
        wr(REG_IEN, 8'h03); chk("R9 masked B", irq, 0);

        // R10: write-one-to-clear
        wr(REG_COUNT, 8'h90);
        pre_tick = 5'b00001; step(); pre_tick = '0;
        rd(REG_FLAG, v); chk("R10 setup", v, 6);
        wr(REG_FLAG, 8'h00);
        rd(REG_FLAG, v); chk("R10 zero no effect", v, 6);
        wr(REG_FLAG, 8'h02);
        rd(REG_FLAG, v); chk("R10 clear A only", v, 4);

        // R11: acknowledge, and set beating clear
        irq_ack = 3'b100; step(); irq_ack = '0;
        rd(REG_FLAG, v); chk("R11 ack clears", v, 0);
        wr(REG_COUNT, 8'h21);
        pre_tick = 5'b00001; irq_ack = 3'b100;
        step();
        pre_tick = '0; irq_ack = '0;
        rd(REG_FLAG, v); chk("R11 set wins", v, 4);
        wr(REG_CTRL, 8'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule